// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of a small RISC core. It is purely combinational: two 8-bit operands, the current carry and zero flags from the status register, and a 5-bit operation code go in. An 8-bit result, six candidate flag values and a six-bit update mask come out. The status register writes only the flags whose mask bit is set and keeps every other flag as it was. Each operation therefore changes its own fixed set of flags.

The operations are add and subtract with and without carry, AND, OR, XOR, one's and two's complement, increment, decrement, logical and arithmetic shifts, rotates through carry, and nibble swap. Test and clear are issued as AND or XOR of a register with itself. Subtract with carry folds the incoming zero flag into its zero result, so a chain of byte subtractions gives a correct zero flag for the whole multi-byte value.

Top module: `alu8`

## Requirements
- R1: Flag and mask bits share one layout: bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S, bit 5 H. A flag bit whose mask bit is 0 reads 0. Codes 17 to 31 return `a_in` unchanged with an all-zero mask.
- R2: Code 0 (add) and code 1 (add with carry, adding `c_in`) return the low 8 bits of the sum. C is the carry out of bit 7, H is the carry out of bit 3 and V is signed overflow. The mask is 0x3F.
- R3: Code 2 (subtract) and code 3 (subtract with carry) return `a_in - b_in`, or `a_in - b_in - c_in` for code 3. C is set when a borrow occurs, H is the borrow into bit 4 and V is signed overflow. The mask is 0x3F.
- R4: For code 3, Z is 1 only when the result is zero and `z_in` is 1. For code 2, Z is 1 exactly when the result is zero.
- R5: Codes 4, 5 and 6 (AND, OR, XOR of `a_in` and `b_in`) force V to 0. The mask is 0x1E, so C and H are left alone.
- R6: Code 7 (one's complement) returns 0xFF - `a_in` with C = 1, V = 0 and mask 0x1F. Code 8 (two's complement) returns 0x00 - `a_in`. For code 8, C is set when the result is non-zero, V is set when `a_in` = 0x80, H is set when the low nibble of `a_in` is non-zero, and the mask is 0x3F.
- R7: Code 9 (increment) sets V when `a_in` = 0x7F and code 10 (decrement) sets V when `a_in` = 0x80. Both use mask 0x1E, so carry is never changed.
- R8: Code 11 (shift left) puts 0 into bit 0 and code 12 (shift right) puts 0 into bit 7. C takes the bit shifted out, V = N xor C, and the mask is 0x1F.
- R9: Code 13 (rotate left) puts `c_in` into bit 0 and takes C from bit 7. Code 14 (rotate right) puts `c_in` into bit 7 and takes C from bit 0. For both, V = N xor C and the mask is 0x1F.
- R10: Code 15 (arithmetic shift right) keeps bit 7, shifts bits 7..1 down one place and takes C from bit 0. V = N xor C and the mask is 0x1F.
- R11: Code 16 (nibble swap) exchanges bits 7..4 with bits 3..0 and has an all-zero mask.
- R12: Whenever their mask bits are set, N equals result bit 7, S equals N xor V, and Z equals "result is zero" (except as stated in R4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation code |
| a_in | input | 8 | First operand (destination register value) |
| b_in | input | 8 | Second operand |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| result | output | 8 | Operation result |
| flags | output | 6 | New flag values, masked |
| flag_mask | output | 6 | Flags this operation updates |

## Verification
The two-operand operations are swept over every pair of operand values with both carry inputs. Subtract with carry is also swept with both zero inputs, which separates the chained zero rule from a plain zero test. The full sweep reaches every boundary: the carry and borrow edges at bits 3 and 7, signed overflow into and out of 0x80, and zero results. The one-operand operations are swept over every operand with both carry and zero inputs and with a second operand that changes at every step. This shows that the second operand has no effect on them and that only the rotates use the carry. The unused codes are swept as well, to show they pass `a_in` through and update no flag.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int FLAG_W = 6;
  localparam int OP_W   = 5;

  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_COM = 5'd7,
    OP_NEG = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_LSL = 5'd11,
    OP_LSR = 5'd12, OP_ROL = 5'd13, OP_ROR = 5'd14, OP_ASR = 5'd15,
    OP_SWP = 5'd16
  } alu_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              c;
    logic              h;
    logic              v;
  } core_t;

  // Addition: carries come from the operand and result bits.
  function automatic core_t add_core(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y, logic ci);
    core_t o;
    logic [DATA_W:0] s;
    s     = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
    o.res = s[DATA_W-1:0];
    o.c   = s[DATA_W];
    o.h   = (x[NIB_W-1] & y[NIB_W-1]) | (y[NIB_W-1] & ~o.res[NIB_W-1]) |
            (~o.res[NIB_W-1] & x[NIB_W-1]);
    o.v   = (x[DATA_W-1] & y[DATA_W-1] & ~o.res[DATA_W-1]) |
            (~x[DATA_W-1] & ~y[DATA_W-1] & o.res[DATA_W-1]);
    return o;
  endfunction

  // Subtraction: borrows come from the operand and result bits.
  function automatic core_t sub_core(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y, logic bi);
    core_t o;
    logic [DATA_W:0] d;
    d     = {1'b0, x} - {1'b0, y} - {{DATA_W{1'b0}}, bi};
    o.res = d[DATA_W-1:0];
    o.c   = d[DATA_W];
    o.h   = (~x[NIB_W-1] & y[NIB_W-1]) | (y[NIB_W-1] & o.res[NIB_W-1]) |
            (o.res[NIB_W-1] & ~x[NIB_W-1]);
    o.v   = (x[DATA_W-1] & ~y[DATA_W-1] & ~o.res[DATA_W-1]) |
            (~x[DATA_W-1] & y[DATA_W-1] & o.res[DATA_W-1]);
    return o;
  endfunction

  // Which flags each operation is allowed to write.
  function automatic logic [FLAG_W-1:0] mask_of(alu_op_e o);
    logic [FLAG_W-1:0] m;
    m = '0;
    case (o)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:
        m = '1;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        m[FZ] = 1'b1; m[FN] = 1'b1; m[FV] = 1'b1; m[FS] = 1'b1;
      end
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        m[FC] = 1'b1; m[FZ] = 1'b1; m[FN] = 1'b1; m[FV] = 1'b1; m[FS] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output core_t             out
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    case (op)
      OP_ADC:  out = add_core(a, b, cin);
      OP_SUB:  out = sub_core(a, b, 1'b0);
      OP_SBC:  out = sub_core(a, b, cin);
      OP_NEG:  out = sub_core('0, a, 1'b0);
      OP_INC:  out = add_core(a, ONE, 1'b0);
      OP_DEC:  out = sub_core(a, ONE, 1'b0);
      default: out = add_core(a, b, 1'b0);
    endcase
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              c
);
  always_comb begin
    c = 1'b0;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: begin
        res = ~a;
        c   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              c
);
  logic [DATA_W-1:0] swapped;

  // Exchange the two halves, one bit per generate iteration.
  for (genvar i = 0; i < NIB_W; i++) begin : g_swap
    assign swapped[i]         = a[i + NIB_W];
    assign swapped[i + NIB_W] = a[i];
  end

  always_comb begin
    c = a[0];
    case (op)
      OP_LSL: begin res = {a[DATA_W-2:0], 1'b0}; c = a[DATA_W-1]; end
      OP_ROL: begin res = {a[DATA_W-2:0], cin};  c = a[DATA_W-1]; end
      OP_LSR:  res = {1'b0, a[DATA_W-1:1]};
      OP_ROR:  res = {cin, a[DATA_W-1:1]};
      OP_ASR:  res = {a[DATA_W-1], a[DATA_W-1:1]};
      default: begin res = swapped; c = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu8.sv
module alu8
  import alu8_pkg::*;
(
  input  logic [4:0] op,
  input  logic [7:0] a_in,
  input  logic [7:0] b_in,
  input  logic       c_in,
  input  logic       z_in,
  output logic [7:0] result,
  output logic [5:0] flags,
  output logic [5:0] flag_mask
);
  alu_op_e           op_e;
  core_t             ar_out;
  logic [DATA_W-1:0] lg_res, sh_res;
  logic              lg_c, sh_c;

  // Named internal events, visible to the checker.
  logic              zero_raw;
  logic              f_c, f_h, f_v, f_n, f_z, f_s;
  logic [FLAG_W-1:0] raw_flags;

  assign op_e = alu_op_e'(op);

  alu8_arith u_arith (.op(op_e), .a(a_in), .b(b_in), .cin(c_in), .out(ar_out));
  alu8_logic u_logic (.op(op_e), .a(a_in), .b(b_in), .res(lg_res), .c(lg_c));
  alu8_shift u_shift (.op(op_e), .a(a_in), .cin(c_in), .res(sh_res), .c(sh_c));

  always_comb begin
    f_h = 1'b0;
    case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC: begin
        result = ar_out.res;
        f_c    = ar_out.c;
        f_h    = ar_out.h;
        f_v    = ar_out.v;
      end
      OP_AND, OP_OR, OP_XOR, OP_COM: begin
        result = lg_res;
        f_c    = lg_c;
        f_v    = 1'b0;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR, OP_SWP: begin
        result = sh_res;
        f_c    = sh_c;
        f_v    = sh_res[DATA_W-1] ^ sh_c;
      end
      default: begin
        result = a_in;
        f_c    = 1'b0;
        f_v    = 1'b0;
      end
    endcase
  end

  assign zero_raw  = (result == '0);
  assign f_n       = result[DATA_W-1];
  assign f_z       = (op_e == OP_SBC) ? (zero_raw & z_in) : zero_raw;
  assign f_s       = f_n ^ f_v;
  assign raw_flags = {f_h, f_s, f_v, f_n, f_z, f_c};
  assign flag_mask = mask_of(op_e);
  assign flags     = raw_flags & flag_mask;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk (
  input logic [4:0] op,
  input logic [7:0] a_in,
  input logic       c_in,
  input logic [7:0] result,
  input logic [5:0] flags,
  input logic [5:0] flag_mask,
  input logic       zero_raw
);
  always_comb begin
    if (!$isunknown({op, a_in, c_in, result, flags, flag_mask})) begin
      p_masked_zero_r1: assert ((flags & ~flag_mask) == 6'd0);
      if (op > 5'd16)
        p_unused_pass_r1: assert (result == a_in && flag_mask == 6'd0);
      if (op >= 5'd4 && op <= 5'd6)
        p_logic_v_r5: assert (!flags[3] && !flag_mask[0] && !flag_mask[5]);
      if (op == 5'd9 || op == 5'd10)
        p_keep_carry_r7: assert (!flag_mask[0]);
      if (op == 5'd13)
        p_rotate_r9: assert (result[0] == c_in && flags[0] == a_in[7]);
      if (op == 5'd16)
        p_swap_r11: assert (flag_mask == 6'd0 && result == {a_in[3:0], a_in[7:4]});
      if (flag_mask[4])
        p_sign_r12: assert (flags[4] == (flags[2] ^ flags[3]));
      if (flag_mask[2])
        p_neg_msb_r12: assert (flags[2] == result[7]);
      if (flag_mask[1] && op != 5'd3)
        p_zero_r12: assert (flags[1] == zero_raw);
    end
  end
endmodule

bind alu8 alu8_chk u_chk (
  .op(op), .a_in(a_in), .c_in(c_in), .result(result),
  .flags(flags), .flag_mask(flag_mask), .zero_raw(zero_raw)
);

// File: tb/alu8_tb.sv
`timescale 1ns/1ps
module alu8_tb;
  logic       clk = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a_in = '0, b_in = '0;
  logic       c_in = 1'b0, z_in = 1'b0;
  logic [7:0] result;
  logic [5:0] flags, flag_mask;
  int         n_checks = 0, n_bad = 0, cycles = 0;
  bit         done = 1'b0;

  alu8 u_dut (.op(op), .a_in(a_in), .b_in(b_in), .c_in(c_in), .z_in(z_in),
              .result(result), .flags(flags), .flag_mask(flag_mask));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 180000 && !done) begin
      done = 1'b1;
      n_checks++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=180000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  function automatic string tag_of(int o);
    case (o)
      0, 1:       return "R2";
      2:          return "R3";
      3:          return "R4";
      4, 5, 6:    return "R5";
      7, 8:       return "R6";
      9, 10:      return "R7";
      11, 12:     return "R8";
      13, 14:     return "R9";
      15:         return "R10";
      16:         return "R11";
      default:    return "R1";
    endcase
  endfunction

  function automatic int sgn(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // Expected behaviour, written from the requirements in integer arithmetic.
  task automatic model(input int o, input int a, input int b, input int c, input int z,
                       output int res, output logic [5:0] fl, output logic [5:0] mk);
    logic fc, fz, fn, fv, fs, fh;
    int   t, cc, sr;
    fc = 0; fh = 0; fv = 0; res = a; mk = 6'h00;
    case (o)
      0, 1: begin
        cc = (o == 1) ? c : 0;
        t = a + b + cc; res = t % 256; fc = (t > 255);
        fh = ((a % 16) + (b % 16) + cc) > 15;
        sr = sgn(a) + sgn(b) + cc; fv = (sr > 127) || (sr < -128);
        mk = 6'h3F;
      end
      2, 3: begin
        cc = (o == 3) ? c : 0;
        t = a - b - cc; res = (t + 512) % 256; fc = (t < 0);
        fh = (a % 16) < ((b % 16) + cc);
        sr = sgn(a) - sgn(b) - cc; fv = (sr > 127) || (sr < -128);
        mk = 6'h3F;
      end
      4: begin res = a & b; mk = 6'h1E; end
      5: begin res = a | b; mk = 6'h1E; end
      6: begin res = a ^ b; mk = 6'h1E; end
      7: begin res = 255 - a; fc = 1; mk = 6'h1F; end
      8: begin res = (256 - a) % 256; fc = (a != 0); fh = (a % 16) != 0; fv = (a == 128); mk = 6'h3F; end
      9:  begin res = (a + 1) % 256;   fv = (a == 127); mk = 6'h1E; end
      10: begin res = (a + 255) % 256; fv = (a == 128); mk = 6'h1E; end
      11: begin res = (a * 2) % 256;     fc = (a >= 128); end
      12: begin res = a / 2;             fc = (a % 2) != 0; end
      13: begin res = (a * 2) % 256 + c; fc = (a >= 128); end
      14: begin res = a / 2 + 128 * c;   fc = (a % 2) != 0; end
      15: begin res = a / 2 + (a / 128) * 128; fc = (a % 2) != 0; end
      16: begin res = (a % 16) * 16 + a / 16; end
      default: res = a;
    endcase
    if (o >= 11 && o <= 15) begin
      fv = (res >= 128) ^ fc;
      mk = 6'h1F;
    end
    fn = (res >= 128);
    fs = fn ^ fv;
    fz = (res == 0);
    if (o == 3) fz = fz && (z != 0);
    fl = {fh, fs, fv, fn, fz, fc} & mk;
  endtask

  task automatic apply(input int o, input int a, input int b, input int c, input int z);
    int         er;
    logic [5:0] ef, em;
    op = 5'(o); a_in = 8'(a); b_in = 8'(b); c_in = 1'(c); z_in = 1'(z);
    #1;
    model(o, a, b, c, z, er, ef, em);
    n_checks++;
    if (result !== 8'(er) || flags !== ef || flag_mask !== em) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h c=%0d z=%0d: actual res=%h fl=%b mk=%b expected res=%h fl=%b mk=%b",
               tag_of(o), o, a, b, c, z, result, flags, flag_mask, 8'(er), ef, em);
    end
    #1;
  endtask

  initial begin
    #4;
    // R1: unused codes pass a_in through with no flags
    for (int o = 17; o < 32; o++)
      for (int a = 0; a < 256; a++)
        apply(o, a, 255 - a, a % 2, 1);
    // R11, R6..R10: one-operand codes; b_in moves every step and must not matter
    for (int o = 7; o <= 16; o++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++)
          for (int z = 0; z < 2; z++)
            apply(o, a, (a * 7 + c + 3 * z) % 256, c, z);
    // R2, R3, R5, R12: every operand pair with both carries
    for (int o = 0; o <= 6; o++) begin
      if (o == 3) continue;
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          for (int c = 0; c < 2; c++)
            apply(o, a, b, c, (a + b) % 2);
    end
    // R4: subtract with carry, zero chaining from z_in
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          for (int z = 0; z < 2; z++)
            apply(3, a, b, c, z);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule